// File: doc/BRIEF.md
# LIN Break Field UART Receiver

This block is the receive half of an asynchronous serial port that can also recognise the long dominant (low) pulse that opens a LIN header. In its ordinary mode it takes an oversampled serial input, confirms each start bit at mid-bit, shifts in eight data bits least significant first, optionally checks a parity bit, samples the stop bit and hands the byte to a one-entry receive buffer. Parity, framing and overrun conditions are reported on three flags.

When software arms break reception, the same start detection runs, but instead of framing a byte the block measures how many baud ticks the line stays low. A low period longer than ten and a half bit times, ended by a return to high, counts as a valid break: the completion pulse fires and the arm and busy bits clear themselves. A shorter low period is dropped without a pulse, and the block waits for the next falling edge still in break mode. A break never writes the buffer and never touches the error flags. Baud rate generation lies outside the block; it receives one tick per oversample period.

Top module: `lin_brk_uart_rx`

## Requirements
- R1: Reception starts only once `rx_en` rises while `pwr_en` is already high; if `rx_en` is raised first and `pwr_en` second, frames are ignored (no `rx_done`, `rx_data` unchanged) until `rx_en` is dropped and raised again.
- R2: Dropping `rx_en` or `pwr_en` in the middle of a frame abandons it: no `rx_done` pulse is produced for that frame, and a later complete frame is received normally.
- R3: With 16 baud ticks per bit, a low level still present 8 ticks after the falling edge starts a frame of eight data bits, LSB first, and one stop bit; the byte appears on `rx_data` with one `rx_done` pulse. A low pulse shorter than 8 ticks produces nothing.
- R4: With `par_en` high a parity bit follows the data; `par_odd`=1 selects odd parity, 0 even. A parity mismatch sets `err_par`, a low stop bit sets `err_frm`; both flags are rewritten by every completed normal frame.
- R5: A normal frame completing while `buf_full` is set and `rd_ack` is low sets `err_ovr` and leaves `rx_data` unchanged; `rd_ack` high in the completion cycle counts as a read, so no overrun is flagged and the new byte is stored. `buf_full` sets on each stored frame and clears on `rd_ack`.
- R6: A pulse on `arm_set` sets `brk_ctl[6]`; in armed mode a start bit confirmed at mid-bit sets `brk_ctl[7]`. All other `brk_ctl` bits read 0.
- R7: In armed mode, a low period of 169 ticks or more (over 10.5 bit times) followed by a high level gives one `rx_done` pulse and clears `brk_ctl[7]` and `brk_ctl[6]`; later frames are received in normal mode.
- R8: A valid break leaves `rx_data` (0xFF after reset), `buf_full`, `err_ovr`, `err_par` and `err_frm` unchanged.
- R9: In armed mode, a low period of 168 ticks or fewer produces no `rx_done`, leaves `brk_ctl[7:6]` at 1, and the next falling edge is again measured as a break.
- R10: `rx_done` is high for exactly one clock cycle per completion.
- R11: After reset `rx_data` is 0xFF and `rx_done`, `brk_ctl`, `buf_full` and the three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per oversample period (16 per bit by default) |
| ser_in | input | 1 | Serial receive line, asynchronous |
| pwr_en | input | 1 | Power enable for the receiver |
| rx_en | input | 1 | Receive enable, effective on a rise while `pwr_en` is high |
| par_en | input | 1 | Expect a parity bit after the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| arm_set | input | 1 | Pulse to arm break reception |
| rd_ack | input | 1 | Pulse marking that `rx_data` has been read |
| rx_data | output | 8 | Receive buffer, 0xFF after reset |
| rx_done | output | 1 | Single-cycle completion pulse (frame or valid break) |
| brk_ctl | output | 8 | Bit 7 break in progress, bit 6 break armed, others 0 |
| buf_full | output | 1 | Buffer holds an unread byte |
| err_ovr | output | 1 | Overrun on the last normal frame |
| err_par | output | 1 | Parity error on the last normal frame |
| err_frm | output | 1 | Framing error on the last normal frame |

## Verification
The completion of a normal frame and a buffer read can land in the same clock cycle, and the block must then treat the buffer as emptied, store the new byte and leave the overrun flag clear. The bench places a single-cycle `rd_ack` in the exact cycle the completion reaches the buffer, counted from the falling edge through the two synchronizer stages, the mid-bit start check and nine bit periods, and judges `err_ovr`, `rx_data` and `buf_full` against those expected from R5. A second coincidence, a valid break finishing while the buffer is still full from an unacknowledged frame, is judged by checking that the buffer, its full flag and the overrun flag all survive the break.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRK
   } rx_state_e;

   // Ticks in ten and a half bit periods; a break must exceed this.
   function automatic int unsigned brk_ticks(int unsigned ovs);
      return (ovs * 21) / 2;
   endfunction

endpackage

// File: rtl/lbr_sync.sv
module lbr_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lbr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {STAGES{RST_VAL}};
      else        q <= {q[STAGES-2:0], din};
   end

   assign dout = q[STAGES-1];

endmodule

// File: rtl/lbr_enable.sv
module lbr_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic rx_en,
   output logic live
);

   logic rx_en_q;
   logic live_q;

   // Live only when rx_en rises with power already on; held while both stay high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en_q <= 1'b0;
         live_q  <= 1'b0;
      end else begin
         rx_en_q <= rx_en;
         live_q  <= pwr_en & rx_en & (live_q | ~rx_en_q);
      end
   end

   assign live = live_q;

endmodule

// File: rtl/lbr_rx_core.sv
module lbr_rx_core
   import lbr_pkg::*;
#(
   parameter int unsigned OVS            = 16,
   parameter int unsigned DATA_W         = 8,
   parameter bit          PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              live,
   input  logic              tick,
   input  logic              rx_s,
   input  logic              brk_arm,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              frm_evt,
   output logic [DATA_W-1:0] frm_data,
   output logic              frm_perr,
   output logic              frm_ferr,
   output logic              brk_start_evt,
   output logic              brk_ok_evt,
   output logic              brk_short_evt,
   output logic              busy
);

   localparam int unsigned HALF    = OVS / 2;
   localparam int unsigned BRK_MIN = brk_ticks(OVS) + 1;
   localparam int unsigned CNT_W   = $clog2(OVS);
   localparam int unsigned IDX_W   = $clog2(DATA_W + 1);
   localparam int unsigned WID_W   = $clog2(BRK_MIN + 1) + 1;

   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
   localparam logic [WID_W-1:0] WID_MIN  = WID_W'(BRK_MIN);

   rx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shf;
   logic              pbit;
   logic [WID_W-1:0]  wid;
   logic              par_on;

   if (PARITY_SUPPORT) begin : g_par
      assign par_on = par_en;
   end else begin : g_nopar
      assign par_on = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         cnt           <= '0;
         idx           <= '0;
         shf           <= '0;
         pbit          <= 1'b0;
         wid           <= '0;
         frm_evt       <= 1'b0;
         frm_data      <= '0;
         frm_perr      <= 1'b0;
         frm_ferr      <= 1'b0;
         brk_start_evt <= 1'b0;
         brk_ok_evt    <= 1'b0;
         brk_short_evt <= 1'b0;
      end else begin
         frm_evt       <= 1'b0;
         brk_start_evt <= 1'b0;
         brk_ok_evt    <= 1'b0;
         brk_short_evt <= 1'b0;
         if (!live) begin
            st  <= ST_IDLE;
            cnt <= '0;
         end else if (tick) begin
            case (st)
               ST_IDLE: begin
                  if (!rx_s) begin
                     st  <= ST_START;
                     cnt <= '0;
                     wid <= WID_W'(1);
                  end
               end
               ST_START: begin
                  if (cnt == CNT_MID) begin
                     cnt <= '0;
                     if (rx_s) begin
                        st <= ST_IDLE;
                     end else if (brk_arm) begin
                        st            <= ST_BRK;
                        brk_start_evt <= 1'b1;
                        wid           <= wid + 1'b1;
                     end else begin
                        st  <= ST_DATA;
                        idx <= '0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                     wid <= wid + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == CNT_LAST) begin
                     cnt <= '0;
                     shf <= {rx_s, shf[DATA_W-1:1]};
                     idx <= idx + 1'b1;
                     if (idx == IDX_LAST) st <= par_on ? ST_PAR : ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (cnt == CNT_LAST) begin
                     cnt  <= '0;
                     pbit <= rx_s;
                     st   <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == CNT_LAST) begin
                     cnt      <= '0;
                     st       <= ST_IDLE;
                     frm_evt  <= 1'b1;
                     frm_data <= shf;
                     frm_ferr <= ~rx_s;
                     frm_perr <= par_on & ((^shf ^ pbit) != par_odd);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_BRK: begin
                  if (rx_s) begin
                     st <= ST_IDLE;
                     if (wid >= WID_MIN) brk_ok_evt    <= 1'b1;
                     else                brk_short_evt <= 1'b1;
                  end else if (wid != '1) begin
                     wid <= wid + 1'b1;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy = (st != ST_IDLE);

endmodule

// File: rtl/lbr_regs.sv
module lbr_regs #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_set,
   input  logic              rd_ack,
   input  logic              frm_evt,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              frm_perr,
   input  logic              frm_ferr,
   input  logic              brk_start_evt,
   input  logic              brk_ok_evt,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic              brk_arm,
   output logic              brk_stat,
   output logic              buf_full,
   output logic              err_ovr,
   output logic              err_par,
   output logic              err_frm
);

   logic hold_old;
   assign hold_old = buf_full & ~rd_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= {DATA_W{1'b1}};
         rx_done  <= 1'b0;
         brk_arm  <= 1'b0;
         brk_stat <= 1'b0;
         buf_full <= 1'b0;
         err_ovr  <= 1'b0;
         err_par  <= 1'b0;
         err_frm  <= 1'b0;
      end else begin
         rx_done <= frm_evt | brk_ok_evt;
         if (brk_ok_evt) begin
            brk_arm  <= 1'b0;
            brk_stat <= 1'b0;
         end else begin
            if (arm_set)       brk_arm  <= 1'b1;
            if (brk_start_evt) brk_stat <= 1'b1;
         end
         if (frm_evt) begin
            err_par  <= frm_perr;
            err_frm  <= frm_ferr;
            err_ovr  <= hold_old;
            buf_full <= 1'b1;
            if (!hold_old) rx_data <= frm_data;
         end else if (rd_ack) begin
            buf_full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/lin_brk_uart_rx.sv
module lin_brk_uart_rx #(
   parameter int unsigned OVS            = 16,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DATA_W         = 8,
   parameter bit          PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              ser_in,
   input  logic              pwr_en,
   input  logic              rx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              arm_set,
   input  logic              rd_ack,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic [7:0]        brk_ctl,
   output logic              buf_full,
   output logic              err_ovr,
   output logic              err_par,
   output logic              err_frm
);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("lin_brk_uart_rx: OVS must be even and at least 4");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("lin_brk_uart_rx: DATA_W must lie between 5 and 9");
   end

   logic              rx_s;
   logic              live;
   logic              busy;
   logic              frm_evt;
   logic [DATA_W-1:0] frm_data;
   logic              frm_perr;
   logic              frm_ferr;
   logic              brk_start_evt;
   logic              brk_ok_evt;
   logic              brk_short_evt;
   logic              brk_arm;
   logic              brk_stat;

   lbr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ser_in),
      .dout (rx_s)
   );

   lbr_enable u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .pwr_en(pwr_en),
      .rx_en (rx_en),
      .live  (live)
   );

   lbr_rx_core #(
      .OVS           (OVS),
      .DATA_W        (DATA_W),
      .PARITY_SUPPORT(PARITY_SUPPORT)
   ) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .live         (live),
      .tick         (baud_tick),
      .rx_s         (rx_s),
      .brk_arm      (brk_arm),
      .par_en       (par_en),
      .par_odd      (par_odd),
      .frm_evt      (frm_evt),
      .frm_data     (frm_data),
      .frm_perr     (frm_perr),
      .frm_ferr     (frm_ferr),
      .brk_start_evt(brk_start_evt),
      .brk_ok_evt   (brk_ok_evt),
      .brk_short_evt(brk_short_evt),
      .busy         (busy)
   );

   lbr_regs #(.DATA_W(DATA_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_set      (arm_set),
      .rd_ack       (rd_ack),
      .frm_evt      (frm_evt),
      .frm_data     (frm_data),
      .frm_perr     (frm_perr),
      .frm_ferr     (frm_ferr),
      .brk_start_evt(brk_start_evt),
      .brk_ok_evt   (brk_ok_evt),
      .rx_data      (rx_data),
      .rx_done      (rx_done),
      .brk_arm      (brk_arm),
      .brk_stat     (brk_stat),
      .buf_full     (buf_full),
      .err_ovr      (err_ovr),
      .err_par      (err_par),
      .err_frm      (err_frm)
   );

   assign brk_ctl = {brk_stat, brk_arm, 6'b000000};

endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              live,
   input logic              busy,
   input logic              brk_ok_evt,
   input logic              brk_short_evt,
   input logic              rd_ack,
   input logic              rx_done,
   input logic              brk_arm,
   input logic              brk_stat,
   input logic [DATA_W-1:0] rx_data,
   input logic              buf_full,
   input logic              err_ovr,
   input logic              err_par,
   input logic              err_frm
);

   // R10: completion pulse lasts one cycle
   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R2: a disabled receiver is idle on the next cycle
   assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> !busy);

   // R7: valid break raises the pulse and clears arm and status
   assert_brk_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_ok_evt |=> rx_done && !brk_arm && !brk_stat);

   // R8: valid break leaves the buffer and its full flag alone
   assert_brk_keeps_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_ok_evt && !rd_ack |=> $stable(rx_data) && $stable(buf_full));

   // R8: valid break leaves the error flags alone
   assert_brk_keeps_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_ok_evt |=> $stable(err_ovr) && $stable(err_par) && $stable(err_frm));

   // R9: short break keeps arm and status set, no pulse
   assert_short_keeps_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_short_evt |=> brk_arm && brk_stat && !rx_done);

endmodule

bind lin_brk_uart_rx lbr_checker #(.DATA_W(DATA_W)) u_lbr_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .live         (live),
   .busy         (busy),
   .brk_ok_evt   (brk_ok_evt),
   .brk_short_evt(brk_short_evt),
   .rd_ack       (rd_ack),
   .rx_done      (rx_done),
   .brk_arm      (brk_arm),
   .brk_stat     (brk_stat),
   .rx_data      (rx_data),
   .buf_full     (buf_full),
   .err_ovr      (err_ovr),
   .err_par      (err_par),
   .err_frm      (err_frm)
);

// File: tb/test_lin_brk_uart_rx.sv
`timescale 1ns/1ps
module test_lin_brk_uart_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       ser_in = 1'b1;
   logic       pwr_en = 1'b0;
   logic       rx_en = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       arm_set = 1'b0;
   logic       rd_ack = 1'b0;
   logic [7:0] rx_data;
   logic       rx_done;
   logic [7:0] brk_ctl;
   logic       buf_full;
   logic       err_ovr;
   logic       err_par;
   logic       err_frm;

   int n_chk = 0;
   int n_bad = 0;
   int done_cnt = 0;
   int run_len = 0;
   int max_run = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lin_brk_uart_rx i_lin_brk_uart_rx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ser_in(ser_in),
      .pwr_en(pwr_en), .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
      .arm_set(arm_set), .rd_ack(rd_ack), .rx_data(rx_data), .rx_done(rx_done),
      .brk_ctl(brk_ctl), .buf_full(buf_full), .err_ovr(err_ovr),
      .err_par(err_par), .err_frm(err_frm)
   );

   always @(posedge clk) begin
      if (rx_done) begin
         done_cnt <= done_cnt + 1;
         run_len  <= run_len + 1;
         if (run_len + 1 > max_run) max_run <= run_len + 1;
      end else begin
         run_len <= 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Frame: start, 8 data bits LSB first, optional parity, stop; ack_at < 0 means no ack.
   task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                             input logic bad_par, input logic bad_stop, input int ack_at);
      int nb;
      int total;
      logic pb;
      nb    = 9 + (pen ? 1 : 0);
      total = (nb + 1) * 16 + 24;
      pb    = (^d) ^ podd ^ bad_par;
      par_en  = pen;
      par_odd = podd;
      for (int c = 0; c < total; c++) begin
         @(negedge clk);
         if (c / 16 == 0)                ser_in = 1'b0;
         else if (c / 16 <= 8)           ser_in = d[c/16 - 1];
         else if (pen && c / 16 == 9)    ser_in = pb;
         else if (c / 16 == nb)          ser_in = (bad_stop && (c % 16) < 10) ? 1'b0 : 1'b1;
         else                            ser_in = 1'b1;
         rd_ack = (c == ack_at);
      end
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   task automatic low_pulse(input int len);
      @(negedge clk);
      ser_in = 1'b0;
      repeat (len) @(negedge clk);
      ser_in = 1'b1;
      idle(40);
   endtask

   task automatic ack();
      @(negedge clk);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   task automatic arm();
      @(negedge clk);
      arm_set = 1'b1;
      @(negedge clk);
      arm_set = 1'b0;
   endtask

   // {data[7:0], par_en, par_odd, flip parity, low stop}
   localparam logic [11:0] VEC [6] = '{
      {8'hA5, 4'b0000},
      {8'h3C, 4'b1000},
      {8'h81, 4'b1100},
      {8'h7E, 4'b1010},
      {8'h00, 4'b0001},
      {8'hFF, 4'b1111}
   };

   initial begin
      int base;
      logic [7:0] keep;

      idle(5);
      rst_n = 1'b1;
      idle(2);
      // R11 reset state
      chk("R11 rx_data", rx_data, 8'hFF);
      chk("R11 brk_ctl", brk_ctl, 8'h00);
      chk("R11 flags", {rx_done, buf_full, err_ovr, err_par, err_frm}, 5'b0);

      // R1 wrong order: rx_en before pwr_en
      rx_en = 1'b1; idle(3);
      pwr_en = 1'b1; idle(3);
      base = done_cnt;
      send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      chk("R1 no done out of order", done_cnt - base, 0);
      chk("R1 buffer untouched", rx_data, 8'hFF);
      rx_en = 1'b0; idle(3);
      rx_en = 1'b1; idle(3);

      // R6 arm, R9 short break, R7/R8 valid break at reset buffer value
      arm();
      chk("R6 armed", brk_ctl, 8'h40);
      base = done_cnt;
      low_pulse(168);
      chk("R9 short break no done", done_cnt - base, 0);
      chk("R9 R6 arm and status kept", brk_ctl, 8'hC0);
      low_pulse(169);
      chk("R7 valid break done", done_cnt - base, 1);
      chk("R7 arm and status cleared", brk_ctl, 8'h00);
      chk("R8 buffer keeps reset value", rx_data, 8'hFF);
      chk("R8 flags untouched", {buf_full, err_ovr, err_par, err_frm}, 4'b0);

      // R3 R4 vector table
      foreach (VEC[i]) begin
         base = done_cnt;
         send_frame(VEC[i][11:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], -1);
         chk("R3 frame done", done_cnt - base, 1);
         chk("R3 data", rx_data, VEC[i][11:4]);
         chk("R4 parity flag", err_par, VEC[i][3] & VEC[i][1]);
         chk("R4 framing flag", err_frm, VEC[i][0]);
         chk("R5 no overrun", err_ovr, 1'b0);
         ack();
      end

      // R3 glitch rejection
      base = done_cnt;
      low_pulse(5);
      chk("R3 glitch ignored", done_cnt - base, 0);

      // R2 abort mid-frame
      base = done_cnt;
      @(negedge clk); ser_in = 1'b0;
      idle(60);
      rx_en = 1'b0; idle(5);
      ser_in = 1'b1; idle(20);
      rx_en = 1'b1; idle(200);
      chk("R2 aborted frame no done", done_cnt - base, 0);
      send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      chk("R2 recovers", rx_data, 8'hC3);
      chk("R4 flags rewritten", {err_par, err_frm}, 2'b00);

      // R5 completion and read in the same cycle
      send_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 155);
      chk("R5 coincident ack no overrun", err_ovr, 1'b0);
      chk("R5 coincident ack stores byte", rx_data, 8'h96);
      chk("R5 coincident ack full", buf_full, 1'b1);

      // R5 overrun without ack
      send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      chk("R5 overrun flag", err_ovr, 1'b1);
      chk("R5 overrun keeps old", rx_data, 8'h96);

      // R8 valid break while buffer full and overrun set
      keep = rx_data;
      arm();
      base = done_cnt;
      low_pulse(200);
      chk("R7 break done", done_cnt - base, 1);
      chk("R8 buffer kept", rx_data, keep);
      chk("R8 full and overrun kept", {buf_full, err_ovr}, 2'b11);
      chk("R7 cleared", brk_ctl, 8'h00);

      // R7 normal mode after break
      ack();
      base = done_cnt;
      send_frame(8'h42, 1'b0, 1'b0, 1'b0, 1'b0, -1);
      chk("R7 normal after break", rx_data, 8'h42);
      chk("R7 normal done", done_cnt - base, 1);

      // R10 pulse width
      chk("R10 single cycle done", max_run, 1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule